// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the bus-facing protocol engine of a 512-byte serial memory that answers on a two-wire bus. It oversamples the clock and data lines in the system clock domain, finds start and stop conditions, and shifts in the header byte. The header carries a fixed device type, two select bits, one high address bit and the transfer direction. When the header matches, the engine acknowledges and then either takes a word address and data bytes, or returns bytes from the memory array.

The engine holds the only address pointer. A word address loads it. Reads advance it over the full 9-bit range. Writes advance it only inside a 16-byte page. Received data bytes leave the block as one-cycle write strobes. A commit pulse on the stop condition tells the external write engine to start programming. While that engine reports busy, the slave stays off the bus entirely.

The write port has no back-pressure: the bus cannot be stalled, so each strobe must be taken in the cycle it appears. Strobes are at least nine bus clock periods apart. The read port is a plain address/data pair. Data is sampled many system clocks after the address settles, so a combinational or one-cycle read both work. The high address bit in a read header is ignored; a read always starts at the pointer.

Top module: `eeb_bus_slave`

## Requirements
- R1: After reset the data line is released, no write strobe or commit is issued, and the address pointer (rd_addr_o) is 0.
- R2: A start (data falls while clock high) aborts any transfer and begins header reception; a stop (data rises while clock high) returns the engine to idle, where bytes clocked without a new start are not acknowledged.
- R3: The header byte, MSB first, is: bits 7..4 device type 1010, bit 3 compared with dev_sel[1], bit 2 compared with dev_sel[0], bit 1 high address bit, bit 0 direction (1 = read). On a match the slave pulls data low for the ninth clock; on a mismatch it gives no acknowledge and ignores the bus until the next start.
- R4: In a write, the word address and every data byte are acknowledged, and each data byte produces one wr_strobe_o with wr_addr_o = {header bit 1, word address} plus the page offset.
- R5: Successive write bytes step only the low 4 address bits, wrapping inside the 16-byte page while the upper 5 bits stay fixed; later bytes overwrite earlier ones.
- R6: commit_o pulses for one cycle on a stop that follows at least one data byte, and never on a stop after a transfer with no data.
- R7: While busy_i is high the slave never drives the data line and does not acknowledge its own header.
- R8: A read header with no preceding word address returns the byte at the pointer, which is the last accessed address plus one.
- R9: A write header plus word address, then a repeated start and read header, returns the byte at that address.
- R10: In a sequential read the pointer steps all 9 bits after each byte and wraps from 511 to 0.
- R11: If the master does not acknowledge a read byte, the slave stops driving until the next start or stop.
- R12: Read bytes are sent MSB first, and the slave changes its drive only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level (asynchronous) |
| sda_i | input | 1 | Bus data line level (asynchronous) |
| dev_sel | input | 2 | Strap bits compared against header bits 3 and 2 |
| busy_i | input | 1 | Write engine programming; slave stays silent |
| sda_pull_o | output | 1 | 1 = pull data line low (open drain) |
| rd_addr_o | output | 9 | Address pointer, used as array read address |
| rd_data_i | input | 8 | Array byte at rd_addr_o |
| wr_strobe_o | output | 1 | One-cycle write request for a received byte |
| wr_addr_o | output | 9 | Address of the strobed byte |
| wr_data_o | output | 8 | Strobed byte |
| commit_o | output | 1 | One-cycle pulse: start programming staged bytes |

## Verification
The bench aims at page overrun: writing 18 bytes from offset 14 must wrap into the same page, so a design that carried into the upper bits would corrupt the next page. It also forces a mismatch where a wrong comparison would acknowledge. Reads are run across 511 to 0, where a page-limited or 8-bit pointer would return the wrong byte. Other targets are a header sent during programming, bytes clocked after a master NACK or after a stop, and a data-less write, where a careless engine would acknowledge, drive the line or issue a false commit.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACKWAIT,
    ST_ACK,
    ST_TX,
    ST_RACK
  } eeb_state_e;

  typedef enum logic [1:0] {
    RX_HDR,
    RX_WORD,
    RX_DATA
  } eeb_rx_e;
endpackage

// File: rtl/eeb_sync.sv
module eeb_sync #(
  parameter int STAGES  = 2,
  parameter bit RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) r <= {STAGES{RST_VAL}};
    else        r <= {r[STAGES-2:0], d};
  end

  assign q = r[STAGES-1];
endmodule

// File: rtl/eeb_line_events.sv
module eeb_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  // data moves while clock stays high: bus conditions
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eeb_addr_ctr.sv
module eeb_addr_ctr #(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              step_page,
  input  logic              step_all,
  output logic [ADDR_W-1:0] q
);
  logic [ADDR_W-1:0] paged;

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      assign paged = {q[ADDR_W-1:PAGE_W], q[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_flat
      assign paged = q + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (load)      q <= load_val;
    else if (step_page) q <= paged;
    else if (step_all)  q <= q + ADDR_W'(1);
  end
endmodule

// File: rtl/eeb_proto.sv
module eeb_proto
  import eeb_pkg::*;
#(
  parameter int         DATA_W   = 8,
  parameter logic [3:0] DEV_TYPE = 4'b1010,
  localparam int        ADDR_W   = DATA_W + 1,
  localparam int        CNT_W    = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [1:0]        dev_sel,
  input  logic              busy_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic [ADDR_W-1:0] ctr_q,
  output logic              ctr_load,
  output logic [ADDR_W-1:0] ctr_load_val,
  output logic              ctr_step_page,
  output logic              ctr_step_all,
  output logic              sda_pull_o,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  eeb_state_e        state;
  eeb_rx_e           kind;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh;
  logic              rw, page, data_seen, mack;

  logic [DATA_W-1:0] rx_byte;
  logic              quiet, byte_done, dev_hit;

  assign rx_byte   = {sh[DATA_W-2:0], sda_s};
  assign quiet     = ~busy_i & ~start_ev & ~stop_ev;
  assign byte_done = quiet && state == ST_RX && scl_rise && bit_cnt == LAST;
  assign dev_hit   = rx_byte[DATA_W-1 -: 4] == DEV_TYPE && rx_byte[3:2] == dev_sel;

  assign ctr_load      = byte_done && kind == RX_WORD;
  assign ctr_load_val  = {page, rx_byte};
  assign ctr_step_page = byte_done && kind == RX_DATA;
  assign ctr_step_all  = quiet && state == ST_TX && scl_fall && bit_cnt == LAST;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      kind        <= RX_HDR;
      bit_cnt     <= '0;
      sh          <= '0;
      rw          <= 1'b0;
      page        <= 1'b0;
      data_seen   <= 1'b0;
      mack        <= 1'b0;
      sda_pull_o  <= 1'b0;
      wr_strobe_o <= 1'b0;
      wr_addr_o   <= '0;
      wr_data_o   <= '0;
      commit_o    <= 1'b0;
    end else begin
      wr_strobe_o <= 1'b0;
      commit_o    <= 1'b0;
      if (busy_i) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        data_seen  <= 1'b0;
      end else if (start_ev) begin
        state      <= ST_RX;
        kind       <= RX_HDR;
        bit_cnt    <= '0;
        sda_pull_o <= 1'b0;
        data_seen  <= 1'b0;
      end else if (stop_ev) begin
        state      <= ST_IDLE;
        sda_pull_o <= 1'b0;
        commit_o   <= data_seen;
        data_seen  <= 1'b0;
      end else begin
        unique case (state)
          ST_RX: begin
            if (scl_rise) begin
              sh      <= rx_byte;
              bit_cnt <= bit_cnt + CNT_W'(1);
              if (bit_cnt == LAST) begin
                unique case (kind)
                  RX_HDR: begin
                    if (dev_hit) begin
                      rw    <= rx_byte[0];
                      page  <= rx_byte[1];
                      state <= ST_ACKWAIT;
                    end else begin
                      state <= ST_IDLE;
                    end
                  end
                  RX_WORD: state <= ST_ACKWAIT;
                  RX_DATA: begin
                    wr_strobe_o <= 1'b1;
                    wr_addr_o   <= ctr_q;
                    wr_data_o   <= rx_byte;
                    data_seen   <= 1'b1;
                    state       <= ST_ACKWAIT;
                  end
                  default: state <= ST_IDLE;
                endcase
              end
            end
          end
          ST_ACKWAIT: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b1;
              state      <= ST_ACK;
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (kind == RX_HDR && rw) begin
                state      <= ST_TX;
                sh         <= rd_data_i;
                sda_pull_o <= ~rd_data_i[DATA_W-1];
              end else begin
                state      <= ST_RX;
                sda_pull_o <= 1'b0;
                kind       <= (kind == RX_HDR) ? RX_WORD : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST) begin
                sda_pull_o <= 1'b0;
                state      <= ST_RACK;
              end else begin
                sh         <= {sh[DATA_W-2:0], 1'b0};
                sda_pull_o <= ~sh[DATA_W-2];
                bit_cnt    <= bit_cnt + CNT_W'(1);
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                state      <= ST_TX;
                sh         <= rd_data_i;
                bit_cnt    <= '0;
                sda_pull_o <= ~rd_data_i[DATA_W-1];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R11
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_IDLE |-> !sda_pull_o);

  // R12
  pull_on_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_s));

  // R7
  busy_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> !sda_pull_o);

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> $past(stop_ev) && !$past(busy_i));

  // R6
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);

  // R4
  strobe_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe_o |-> $past(scl_rise));
endmodule

// File: rtl/eeb_bus_slave.sv
module eeb_bus_slave #(
  parameter int         DATA_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  localparam int        ADDR_W      = DATA_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        dev_sel,
  input  logic              busy_i,
  output logic              sda_pull_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              wr_strobe_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              commit_o
);
  logic [1:0] line_raw, line_s;
  logic       scl_rise, scl_fall, start_ev, stop_ev;
  logic       ctr_load, ctr_step_page, ctr_step_all;
  logic [ADDR_W-1:0] ctr_load_val, ctr_q;

  assign line_raw = {scl_i, sda_i};

  generate
    for (genvar g = 0; g < 2; g++) begin : g_sync
      eeb_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(line_raw[g]), .q(line_s[g])
      );
    end
  endgenerate

  eeb_line_events u_ev (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  eeb_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
    .clk(clk), .rst_n(rst_n),
    .load(ctr_load), .load_val(ctr_load_val),
    .step_page(ctr_step_page), .step_all(ctr_step_all),
    .q(ctr_q)
  );

  eeb_proto #(.DATA_W(DATA_W), .DEV_TYPE(DEV_TYPE)) u_proto (
    .clk(clk), .rst_n(rst_n),
    .scl_s(line_s[1]), .sda_s(line_s[0]),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .dev_sel(dev_sel), .busy_i(busy_i),
    .rd_data_i(rd_data_i), .ctr_q(ctr_q),
    .ctr_load(ctr_load), .ctr_load_val(ctr_load_val),
    .ctr_step_page(ctr_step_page), .ctr_step_all(ctr_step_all),
    .sda_pull_o(sda_pull_o),
    .wr_strobe_o(wr_strobe_o), .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o),
    .commit_o(commit_o)
  );

  assign rd_addr_o = ctr_q;
endmodule

// File: tb/sim_eeb_bus_slave.sv
module sim_eeb_bus_slave;
  localparam int Q        = 10;
  localparam int BUSY_CYC = 1500;
  localparam logic [16:0] VEC [0:5] = '{
    {9'h000, 8'h5A}, {9'h0FF, 8'hC3}, {9'h100, 8'h81},
    {9'h1FF, 8'h3C}, {9'h123, 8'hE7}, {9'h0A5, 8'h00}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] dev_sel = 2'b10;
  logic       busy, sda_pull, wr_strobe, commit;
  logic [8:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  wire        sda_line = sda_m & ~sda_pull;

  logic [7:0] mem [512];
  logic [7:0] ref_mem [512];
  logic [8:0] stg_a [32];
  logic [7:0] stg_d [32];
  int stg_n, busy_cnt, commits, busy_drive;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  assign busy    = busy_cnt != 0;
  assign rd_data = mem[rd_addr];

  eeb_bus_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .dev_sel(dev_sel), .busy_i(busy), .sda_pull_o(sda_pull),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .wr_strobe_o(wr_strobe), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .commit_o(commit)
  );

  // commit engine model: stage strobes, apply on commit, then stay busy
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= 8'(i * 7 + 3);
      stg_n <= 0; busy_cnt <= 0; commits <= 0;
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (wr_strobe && stg_n < 32) begin
        stg_a[stg_n] <= wr_addr; stg_d[stg_n] <= wr_data; stg_n <= stg_n + 1;
      end
      if (commit) begin
        for (int i = 0; i < 32; i++) if (i < stg_n) mem[stg_a[i]] <= stg_d[i];
        stg_n <= 0; busy_cnt <= BUSY_CYC; commits <= commits + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && busy && sda_pull) busy_drive++;

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); sda_m = 1'b0; tick(); scl_m = 1'b0; tick();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(); scl_m = 1'b1; tick(); sda_m = 1'b1; tick();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      tick(); sda_m = b[i]; tick(); scl_m = 1'b1; tick(); tick(); scl_m = 1'b0;
    end
    tick(); sda_m = 1'b1; tick(); scl_m = 1'b1; tick(); ack = !sda_line; tick(); scl_m = 1'b0;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(); tick(); scl_m = 1'b1; tick(); b[i] = sda_line; tick(); scl_m = 1'b0;
    end
    tick(); sda_m = !give_ack; tick(); scl_m = 1'b1; tick(); tick(); scl_m = 1'b0; tick(); sda_m = 1'b1;
  endtask

  function automatic logic [7:0] hdr(bit pg, bit rd);
    return {4'b1010, 2'b10, pg, rd};
  endfunction

  task automatic poll_ready();
    bit ack;
    for (int t = 0; t < 40; t++) begin
      bus_start(); send_byte(hdr(1'b0, 1'b0), ack); bus_stop();
      if (ack) break;
    end
  endtask

  task automatic write_seq(input logic [8:0] a, input int n, input logic [7:0] d0, input string tag);
    bit ack; int miss = 0;
    poll_ready();
    bus_start();
    send_byte(hdr(a[8], 1'b0), ack); if (!ack) miss++;
    send_byte(a[7:0], ack);          if (!ack) miss++;
    for (int i = 0; i < n; i++) begin
      send_byte(8'(d0 + i), ack); if (!ack) miss++;
      ref_mem[{a[8:4], 4'(a[3:0] + 4'(i))}] = 8'(d0 + i);
    end
    bus_stop();
    chk(miss == 0, tag, miss, 0);
  endtask

  task automatic rand_read(input logic [8:0] a, input int n, input string tag);
    bit ack; logic [7:0] b; logic [8:0] ea;
    poll_ready();
    bus_start();
    send_byte(hdr(a[8], 1'b0), ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(hdr(1'b0, 1'b1), ack);
    chk(ack, {tag, " read header ack"}, ack, 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(k < n - 1, b);
      ea = a + 9'(k);
      chk(b == ref_mem[ea], tag, b, ref_mem[ea]);
    end
    bus_stop();
  endtask

  initial begin
    bit ack; logic [7:0] b; int c0;
    for (int i = 0; i < 512; i++) ref_mem[i] = 8'(i * 7 + 3);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(sda_pull == 1'b0, "R1 sda released", sda_pull, 0);
    chk(wr_strobe == 1'b0, "R1 no strobe", wr_strobe, 0);
    chk(commit == 1'b0, "R1 no commit", commit, 0);
    chk(rd_addr == 9'd0, "R1 pointer zero", rd_addr, 0);

    // R3 select mismatch, then a byte without start is ignored
    bus_start(); send_byte(8'hA4, ack);
    chk(!ack, "R3 select mismatch no ack", ack, 0);
    send_byte(hdr(1'b0, 1'b0), ack);
    chk(!ack, "R3 ignored until start", ack, 0);
    bus_stop();
    bus_start(); send_byte(8'hB8, ack);
    chk(!ack, "R3 wrong type no ack", ack, 0);
    bus_stop();

    // vector table: byte write then random read (R4, R9, R12)
    for (int v = 0; v < 6; v++) begin
      write_seq(VEC[v][16:8], 1, VEC[v][7:0], "R4 byte write acks");
      rand_read(VEC[v][16:8], 1, "R9 R12 random read");
    end

    // R7 header during programming is not acknowledged
    write_seq(9'h050, 1, 8'h99, "R4 write before busy");
    bus_start(); send_byte(hdr(1'b0, 1'b0), ack); bus_stop();
    chk(!ack, "R7 no ack while busy", ack, 0);

    // R5 page wrap with 18 bytes from offset 14
    c0 = commits;
    write_seq(9'h02E, 18, 8'h40, "R5 page write acks");
    poll_ready();
    chk(commits == c0 + 1, "R6 one commit per page write", commits, c0 + 1);
    rand_read(9'h020, 16, "R5 page contents");

    // R8 current-address read continues after 0x02F
    bus_start(); send_byte(hdr(1'b0, 1'b1), ack);
    recv_byte(1'b0, b); bus_stop();
    chk(b == ref_mem[9'h030], "R8 current address read", b, ref_mem[9'h030]);

    // R10 sequential read across 511 -> 0
    rand_read(9'h1FE, 4, "R10 sequential wrap");

    // R11 after master NACK the slave stays silent
    poll_ready();
    bus_start(); send_byte(hdr(1'b0, 1'b0), ack); send_byte(8'h00, ack);
    bus_start(); send_byte(hdr(1'b0, 1'b1), ack);
    recv_byte(1'b0, b);
    recv_byte(1'b0, b);
    chk(b == 8'hFF, "R11 silent after NACK", b, 8'hFF);
    bus_stop();

    // R6 no commit without data; R2 stop returns to idle
    c0 = commits;
    bus_start(); send_byte(hdr(1'b0, 1'b0), ack); send_byte(8'h10, ack); bus_stop();
    repeat (50) @(negedge clk);
    chk(commits == c0, "R6 no commit without data", commits, c0);
    chk(!busy, "R6 not busy", busy, 0);
    scl_m = 1'b0; tick();
    send_byte(hdr(1'b0, 1'b0), ack);
    chk(!ack, "R2 idle after stop", ack, 0);
    scl_m = 1'b1; tick();

    chk(busy_drive == 0, "R7 no drive while busy", busy_drive, 0);

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule